// File: doc/BRIEF.md
# Single-Wire Parity Chunk Codec

This block moves short data chunks, one at a time, over a single shared line. The transmit half takes a right-aligned data word and a bit count from 1 to 8. It drives the bits most-significant first, each held for one bit period. It then appends an even-parity bit and pulls the line low, so that the next synchronisation step sees a rising edge.

The receive half is started at the first edge of a chunk. It samples the line at the middle of each bit, shifts the bits into a right-aligned word, and compares its running parity with the received parity bit. Mismatches set a per-chunk flag and advance a wrapping error counter.

Before a chunk, the transmitter can optionally wait for the far end's sync. It waits a bounded time for the line to go low, then waits without limit for the line to return high. The bit period comes from a speed-select parameter (4, 6, 12, 24, 36 or 48 µs) multiplied by the clock rate in MHz. The sample point is the integer half of the period, and the rest of the period follows it. The line input is assumed to be synchronous to the clock. Pin direction and transaction sequencing belong to the surrounding logic.

Top module: `sw_chunk_codec`

## Requirements
- R1: After reset, tx_line_o is 1, tx_busy_o, tx_done_o, rx_busy_o, rx_done_o and rx_perr_o are 0, and rx_data_o and rx_err_cnt_o are 0.
- R2: A chunk accepted at clock edge D (tx_start_i high, tx_busy_o low) drives bit k of the chunk during the cycles between edges D+k·B and D+(k+1)·B. B is the bit period in cycles. Bit 0 of the chunk is tx_data_i[n-1], where n = tx_len_i (1..8) and the data is right-aligned, so bits go out MSB first.
- R3: Right after the last data bit, the transmitter drives for one period a parity bit equal to the XOR of the n data bits (even parity, starting from 0).
- R4: At edge D+(n+1)·B the transmitter drives tx_line_o to 0, drops tx_busy_o, and raises tx_done_o for exactly one cycle. The line then stays 0 until the next chunk starts.
- R5: tx_start_i is ignored while tx_busy_o is high; the chunk in progress keeps its data and timing.
- R6: If tx_sync_i is high when a chunk is accepted at edge t, the transmitter first waits for line_i to be 0. It leaves this wait on the first edge that samples 0, or at edge t+5·B if none does. It then waits for an edge that samples line_i as 1, and that edge is D for the chunk. During both waits tx_line_o keeps its previous value and tx_busy_o is 1.
- R7: A receive started at edge D (rx_start_i high, rx_busy_o low) with n = rx_len_i samples line_i at edge D+k·B+H for bit k, where H is the integer half of B. At edge D+(n+1)·B it puts the n data bits right-aligned on rx_data_o, MSB first received, and raises rx_done_o for one cycle.
- R8: With rx_done_o, rx_perr_o shows whether the received parity bit differs from the XOR of the received data bits. rx_err_cnt_o goes up by one (wrapping) at that edge for each mismatched chunk and changes at no other time.
- R9: rx_start_i is ignored while rx_busy_o is high.
- R10: B equals the speed-select period in µs (select 0..5 maps to 4, 6, 12, 24, 36, 48) times CLK_MHZ. H is B/2 rounded down, and the remaining B−H cycles finish the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_start_i | input | 1 | Request to send one chunk |
| tx_sync_i | input | 1 | Wait for the far end's sync before sending |
| tx_len_i | input | 4 | Chunk length in bits, 1..8 |
| tx_data_i | input | 8 | Chunk data, right-aligned |
| tx_line_o | output | 1 | Level driven onto the line |
| tx_busy_o | output | 1 | Transmit chunk (or its sync wait) in progress |
| tx_done_o | output | 1 | One-cycle pulse at chunk end |
| line_i | input | 1 | Sampled line level, synchronous to clk_i |
| rx_start_i | input | 1 | Marks the first edge of an incoming chunk |
| rx_len_i | input | 4 | Incoming chunk length in bits, 1..8 |
| rx_busy_o | output | 1 | Receive in progress |
| rx_done_o | output | 1 | One-cycle pulse when a chunk has been received |
| rx_data_o | output | 8 | Last received chunk, right-aligned |
| rx_perr_o | output | 1 | Parity mismatch on the last received chunk |
| rx_err_cnt_o | output | 8 | Wrapping count of parity mismatches |

## Verification
The transmitter is looped back into the receiver with random data and lengths, plus the all-ones, all-zeros and single-bit chunks. This shows that bit order, parity polarity and the end-of-chunk timing agree at both ends. Receive-only frames are driven with the correct level only in the single cycle before the sample edge. This separates a mid-bit sampler from one that samples early or late, and injected parity flips separate the error flag and counter from a plain pass-through. Sync waits are tried with an early low pulse and with a line that never goes low, and requests made in the middle of a chunk show that nothing in flight is disturbed.

// File: rtl/sw_chunk_pkg.sv
package sw_chunk_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_SYNC_LO,
    TX_SYNC_HI,
    TX_DATA,
    TX_PAR
  } tx_state_e;

  typedef enum logic {
    RX_IDLE,
    RX_BITS
  } rx_state_e;

  function automatic int unsigned period_us(input int unsigned sel);
    case (sel)
      0:       return 4;
      1:       return 6;
      2:       return 12;
      3:       return 24;
      4:       return 36;
      default: return 48;
    endcase
  endfunction

  function automatic int unsigned bit_cycles(input int unsigned sel, input int unsigned mhz);
    return period_us(sel) * mhz;
  endfunction

  function automatic int unsigned half_first(input int unsigned cyc);
    return cyc / 2;
  endfunction

  function automatic int unsigned half_second(input int unsigned cyc);
    return cyc - cyc / 2;
  endfunction

endpackage

// File: rtl/sw_bit_timer.sv
module sw_bit_timer #(
  parameter int unsigned CYC   = 96,
  parameter int unsigned CNT_W = (CYC > 1) ? $clog2(CYC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = run_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/sw_chunk_tx.sv
module sw_chunk_tx
  import sw_chunk_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned BIT_CYC = 96,
  parameter int unsigned LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sync_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              line_i,
  output logic              line_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int unsigned TMO_CYC = 5 * BIT_CYC;
  localparam int unsigned TMO_W   = $clog2(TMO_CYC);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);
  localparam int unsigned CNT_W   = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;

  tx_state_e         st_q;
  logic [DATA_W-1:0] sh_q;
  logic [LEN_W-1:0]  left_q;
  logic              par_q;
  logic              line_q;
  logic              done_q;
  logic [TMO_W-1:0]  tmo_q;

  logic [DATA_W-1:0] load_sh;
  logic [LEN_W-1:0]  sh_amt;
  logic              accept;
  logic              enter_data;
  logic              t_clr, t_run, t_wrap;
  logic [CNT_W-1:0]  t_cnt;

  // left-align the chunk so the MSB of the chunk sits at the top
  assign sh_amt     = LEN_W'(DATA_W) - len_i;
  assign load_sh    = data_i << sh_amt;
  assign accept     = (st_q == TX_IDLE) && start_i;
  assign enter_data = (accept && !sync_i) || ((st_q == TX_SYNC_HI) && line_i);
  assign t_clr      = enter_data;
  assign t_run      = (st_q == TX_DATA) || (st_q == TX_PAR);

  sw_bit_timer #(.CYC(BIT_CYC), .CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (t_clr),
    .run_i  (t_run),
    .cnt_o  (t_cnt),
    .wrap_o (t_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      sh_q   <= '0;
      left_q <= '0;
      par_q  <= 1'b0;
      line_q <= 1'b1;
      done_q <= 1'b0;
      tmo_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        TX_IDLE: begin
          if (start_i) begin
            sh_q   <= load_sh;
            par_q  <= ^load_sh;
            left_q <= len_i - LEN_W'(1);
            if (sync_i) begin
              st_q  <= TX_SYNC_LO;
              tmo_q <= '0;
            end else begin
              st_q   <= TX_DATA;
              line_q <= load_sh[DATA_W-1];
            end
          end
        end
        TX_SYNC_LO: begin
          tmo_q <= tmo_q + TMO_W'(1);
          if (!line_i || (tmo_q == TMO_LAST)) st_q <= TX_SYNC_HI;
        end
        TX_SYNC_HI: begin
          if (line_i) begin
            st_q   <= TX_DATA;
            line_q <= sh_q[DATA_W-1];
          end
        end
        TX_DATA: begin
          if (t_wrap) begin
            if (left_q == '0) begin
              st_q   <= TX_PAR;
              line_q <= par_q;
            end else begin
              sh_q   <= sh_q << 1;
              line_q <= sh_q[DATA_W-2];
              left_q <= left_q - LEN_W'(1);
            end
          end
        end
        TX_PAR: begin
          if (t_wrap) begin
            st_q   <= TX_IDLE;
            line_q <= 1'b0;   // trailing low gives the next sync a rising edge
            done_q <= 1'b1;
          end
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign line_o = line_q;
  assign busy_o = (st_q != TX_IDLE);
  assign done_o = done_q;

endmodule

// File: rtl/sw_chunk_rx.sv
module sw_chunk_rx
  import sw_chunk_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned BIT_CYC = 96,
  parameter int unsigned ERR_W   = 8,
  parameter int unsigned LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              line_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic [ERR_W-1:0]  err_cnt_o
);

  localparam int unsigned CNT_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int unsigned HALF1 = half_first(BIT_CYC);
  // sample edge sits HALF1 cycles after the bit's first edge; HALF2 cycles remain
  localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(HALF1 - 1);

  rx_state_e         st_q;
  logic [DATA_W-1:0] sh_q;
  logic [LEN_W-1:0]  left_q;
  logic              par_q;
  logic              bad_q;
  logic [DATA_W-1:0] data_q;
  logic              perr_q;
  logic              done_q;
  logic [ERR_W-1:0]  cnt_q;

  logic             t_clr, t_run, t_wrap, smp;
  logic [CNT_W-1:0] t_cnt;

  assign t_clr = (st_q == RX_IDLE) && start_i;
  assign t_run = (st_q == RX_BITS);
  assign smp   = t_run && (t_cnt == SAMPLE_AT);

  sw_bit_timer #(.CYC(BIT_CYC), .CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (t_clr),
    .run_i  (t_run),
    .cnt_o  (t_cnt),
    .wrap_o (t_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      sh_q   <= '0;
      left_q <= '0;
      par_q  <= 1'b0;
      bad_q  <= 1'b0;
      data_q <= '0;
      perr_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          if (start_i) begin
            st_q   <= RX_BITS;
            left_q <= len_i;
            sh_q   <= '0;
            par_q  <= 1'b0;
            bad_q  <= 1'b0;
          end
        end
        RX_BITS: begin
          if (smp) begin
            if (left_q != '0) begin
              sh_q  <= {sh_q[DATA_W-2:0], line_i};
              par_q <= par_q ^ line_i;
            end else begin
              bad_q <= par_q ^ line_i;
            end
          end
          if (t_wrap) begin
            if (left_q == '0) begin
              st_q   <= RX_IDLE;
              done_q <= 1'b1;
              data_q <= sh_q;
              perr_q <= bad_q;
              if (bad_q) cnt_q <= cnt_q + ERR_W'(1);
            end else begin
              left_q <= left_q - LEN_W'(1);
            end
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q == RX_BITS);
  assign done_o    = done_q;
  assign data_o    = data_q;
  assign perr_o    = perr_q;
  assign err_cnt_o = cnt_q;

endmodule

// File: rtl/sw_chunk_codec.sv
module sw_chunk_codec
  import sw_chunk_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_MHZ   = 16,
  parameter int unsigned SPEED_SEL = 1,
  parameter int unsigned ERR_W     = 8,
  parameter int unsigned LEN_W     = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_start_i,
  input  logic              tx_sync_i,
  input  logic [LEN_W-1:0]  tx_len_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_line_o,
  output logic              tx_busy_o,
  output logic              tx_done_o,
  input  logic              line_i,
  input  logic              rx_start_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  output logic              rx_busy_o,
  output logic              rx_done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_perr_o,
  output logic [ERR_W-1:0]  rx_err_cnt_o
);

  localparam int unsigned BIT_CYC = bit_cycles(SPEED_SEL, CLK_MHZ);

  sw_chunk_tx #(
    .DATA_W  (DATA_W),
    .BIT_CYC (BIT_CYC),
    .LEN_W   (LEN_W)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tx_start_i),
    .sync_i (tx_sync_i),
    .len_i  (tx_len_i),
    .data_i (tx_data_i),
    .line_i (line_i),
    .line_o (tx_line_o),
    .busy_o (tx_busy_o),
    .done_o (tx_done_o)
  );

  sw_chunk_rx #(
    .DATA_W  (DATA_W),
    .BIT_CYC (BIT_CYC),
    .ERR_W   (ERR_W),
    .LEN_W   (LEN_W)
  ) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (rx_start_i),
    .len_i    (rx_len_i),
    .line_i   (line_i),
    .busy_o   (rx_busy_o),
    .done_o   (rx_done_o),
    .data_o   (rx_data_o),
    .perr_o   (rx_perr_o),
    .err_cnt_o(rx_err_cnt_o)
  );

endmodule

// File: rtl/sw_chunk_codec_chk.sv
module sw_chunk_codec_chk #(
  parameter int unsigned ERR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_line_o,
  input logic             tx_busy_o,
  input logic             tx_done_o,
  input logic             rx_done_o,
  input logic             rx_perr_o,
  input logic [ERR_W-1:0] rx_err_cnt_o
);

  // R4
  tx_end_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> (!tx_line_o && !tx_busy_o));

  // R4
  tx_done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o);

  // R4
  tx_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_busy_o && !$past(tx_busy_o)) |-> $stable(tx_line_o));

  // R7
  rx_done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);

  // R8
  err_cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_err_cnt_o) |-> (rx_done_o && rx_perr_o));

endmodule

bind sw_chunk_codec sw_chunk_codec_chk #(.ERR_W(ERR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_line_o   (tx_line_o),
  .tx_busy_o   (tx_busy_o),
  .tx_done_o   (tx_done_o),
  .rx_done_o   (rx_done_o),
  .rx_perr_o   (rx_perr_o),
  .rx_err_cnt_o(rx_err_cnt_o)
);

// File: tb/sw_chunk_codec_bench.sv
module sw_chunk_codec_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MHZ  = 2;
  localparam int SPD  = 1;
  localparam int B    = 6 * MHZ;   // R10: select 1 -> 6 us
  localparam int H    = B / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_start = 1'b0, tx_sync = 1'b0;
  logic [3:0] tx_len = 4'd8, rx_len = 4'd8;
  logic [7:0] tx_data = 8'h00;
  logic       rx_start = 1'b0;
  logic       drive_sel = 1'b0, bench_line = 1'b1;
  logic       line;
  logic       tx_line_o, tx_busy_o, tx_done_o;
  logic       rx_busy_o, rx_done_o, rx_perr_o;
  logic [7:0] rx_data_o, rx_err_cnt_o;

  int  n_chk = 0, n_bad = 0;
  bit  finished = 1'b0;
  logic [7:0] exp_cnt = 8'd0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign line = drive_sel ? bench_line : tx_line_o;

  sw_chunk_codec #(.CLK_MHZ(MHZ), .SPEED_SEL(SPD)) u_sw_chunk_codec (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tx_start_i  (tx_start),
    .tx_sync_i   (tx_sync),
    .tx_len_i    (tx_len),
    .tx_data_i   (tx_data),
    .tx_line_o   (tx_line_o),
    .tx_busy_o   (tx_busy_o),
    .tx_done_o   (tx_done_o),
    .line_i      (line),
    .rx_start_i  (rx_start),
    .rx_len_i    (rx_len),
    .rx_busy_o   (rx_busy_o),
    .rx_done_o   (rx_done_o),
    .rx_data_o   (rx_data_o),
    .rx_perr_o   (rx_perr_o),
    .rx_err_cnt_o(rx_err_cnt_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] trim(input logic [7:0] d, input int len);
    return d & 8'((16'd1 << len) - 16'd1);
  endfunction

  // mode 0: no sync, 1: sync with low pulse, 2: sync timeout
  task automatic tx_chunk(input logic [7:0] d, input int len, input int mode, input bit poke);
    logic [7:0] dm;
    logic       p, pre;
    bit         early;
    int         stp;
    dm = trim(d, len);
    p = ^dm;
    early = 1'b0;
    pre = tx_line_o;
    tx_data = d; tx_len = 4'(len); tx_sync = (mode != 0); tx_start = 1'b1;
    rx_len = 4'(len);
    if (mode == 0) begin
      rx_start = 1'b1;
    end else begin
      drive_sel = 1'b1; bench_line = 1'b1;
      stp = (mode == 1) ? 8 : 5 * B + 1;
      for (int m = 1; m <= stp; m++) begin
        @(negedge clk);
        tx_start = 1'b0;
        if (mode == 1 && m == 5) bench_line = 1'b0;
        if (m == stp) bench_line = 1'b1;
        if (m < stp && tx_busy_o !== 1'b1) early = 1'b1;
      end
      chk("R6 line held during sync", int'(tx_line_o), int'(pre));
      chk("R6 busy during sync", int'(early), 0);
      rx_start = 1'b1;
    end
    for (int j = 0; j <= (len + 1) * B; j++) begin
      @(negedge clk);
      if (j == 0) begin tx_start = 1'b0; rx_start = 1'b0; drive_sel = 1'b0; end
      if (poke && j == B) begin tx_start = 1'b1; tx_data = ~d; rx_start = 1'b1; end
      if (poke && j == B + 1) begin tx_start = 1'b0; rx_start = 1'b0; end
      if (j % B == B / 2) begin
        if (j / B < len) chk("R2 data bit", int'(tx_line_o), int'(dm[len - 1 - j / B]));
        else if (j / B == len) chk("R3 parity bit", int'(tx_line_o), int'(p));
      end
      if (j < (len + 1) * B && (tx_done_o || rx_done_o)) early = 1'b1;
    end
    chk("R4 R10 done at chunk end", int'(tx_done_o), 1);
    chk("R4 trailing low", int'(tx_line_o), 0);
    chk("R4 not busy at end", int'(tx_busy_o), 0);
    chk("R4 no early done", int'(early), 0);
    chk("R7 loopback done", int'(rx_done_o), 1);
    chk(poke ? "R5 R9 data kept" : "R7 loopback data", int'(rx_data_o), int'(dm));
    chk("R8 no parity error", int'(rx_perr_o), 0);
    chk("R8 count unchanged", int'(rx_err_cnt_o), int'(exp_cnt));
    repeat (3) @(negedge clk);
    chk("R4 line stays low", int'(tx_line_o), 0);
  endtask

  task automatic rx_frame(input logic [7:0] d, input int len, input bit flip, input bit mid_only);
    logic [7:0] dm;
    logic       pb, v;
    bit         early;
    int         tot;
    dm = trim(d, len);
    pb = (^dm) ^ flip;
    tot = (len + 1) * B;
    early = 1'b0;
    drive_sel = 1'b1; rx_len = 4'(len); rx_start = 1'b1;
    for (int j = 0; j <= tot; j++) begin
      if (j > 0) begin
        @(negedge clk);
        rx_start = 1'b0;
        if (rx_done_o) early = 1'b1;
      end
      if (j < tot) begin
        v = (j / B < len) ? dm[len - 1 - j / B] : pb;
        if (mid_only && (j % B) != H) v = ~v;
        bench_line = v;
      end
    end
    @(negedge clk);
    if (flip) exp_cnt = exp_cnt + 8'd1;
    chk("R7 rx done", int'(rx_done_o), 1);
    chk("R7 no early rx done", int'(early), 0);
    chk("R7 rx data", int'(rx_data_o), int'(dm));
    chk("R8 parity flag", int'(rx_perr_o), int'(flip));
    chk("R8 error count", int'(rx_err_cnt_o), int'(exp_cnt));
    drive_sel = 1'b0;
    bench_line = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd5711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 line idle high", int'(tx_line_o), 1);
    chk("R1 tx idle", int'({tx_busy_o, tx_done_o}), 0);
    chk("R1 rx idle", int'({rx_busy_o, rx_done_o, rx_perr_o}), 0);
    chk("R1 rx data", int'(rx_data_o), 0);
    chk("R1 error count", int'(rx_err_cnt_o), 0);

    tx_chunk(8'hA5, 8, 0, 1'b0);
    tx_chunk(8'h7F, 7, 0, 1'b0);
    tx_chunk(8'hFF, 8, 0, 1'b0);
    tx_chunk(8'h00, 8, 0, 1'b0);
    tx_chunk(8'h01, 1, 0, 1'b0);
    tx_chunk(8'h5C, 7, 0, 1'b1);
    tx_chunk(8'h3B, 8, 1, 1'b0);
    tx_chunk(8'h66, 7, 2, 1'b0);
    for (int i = 0; i < 24; i++) begin
      int len;
      len = ($urandom % 4 == 0) ? int'($urandom % 8) + 1 : 7 + int'($urandom % 2);
      tx_chunk(8'($urandom), len, (i % 6 == 5) ? 1 : 0, (i % 7 == 3));
    end

    rx_frame(8'h96, 8, 1'b0, 1'b1);
    rx_frame(8'h2D, 7, 1'b1, 1'b0);
    rx_frame(8'hFF, 8, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) begin
      rx_frame(8'($urandom), 7 + int'($urandom % 2), 1'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule